// File: doc/BRIEF.md
# Arithmetic Right Shift Unit with Carry Flags

This unit is the shift datapath of a 64-bit integer pipeline. It shifts right arithmetically in two widths. The word form works on the low 32 bits of the operand as a signed value and returns the result sign-extended to 64 bits. The doubleword form works on all 64 bits. Along with the shifted value, it produces a carry flag and a 32-bit carry flag. Both flags say whether a negative operand lost nonzero bits off its low end.

The count comes from a 7-bit input. This input may be fed from a register value or from an immediate, and the behaviour is the same either way. The upper count bits do not wrap: they turn an oversized count into a fill with the sign bit. A valid strobe starts one operation. The result, both flags and a result-valid pulse appear on registered outputs one clock later. Decode, the register file and the status-register writeback live outside the block.

Top module: `sra_carry_unit`

## Requirements
- R1: With `op_i`=0 (word form) and `cnt_i[5]`=0, the result is the low 32 bits of `src_i`, taken as signed, shifted right arithmetically by `cnt_i[4:0]` and sign-extended to 64 bits. `cnt_i[6]` has no effect in the word form.
- R2: With `op_i`=0 and `cnt_i[5]`=1, every one of the 64 result bits equals `src_i[31]`, and the carry equals `src_i[31]`.
- R3: With `op_i`=1 (doubleword form) and `cnt_i[6]`=0, the result is `src_i` shifted right arithmetically by `cnt_i[5:0]`.
- R4: With `op_i`=1 and `cnt_i[6]`=1, every result bit equals `src_i[63]`, and the carry equals `src_i[63]`.
- R5: For a nonzero in-range count, the carry is 1 exactly when both of these hold: the operand's sign bit is 1, and at least one 1 bit was shifted out. Otherwise the carry is 0.
- R6: For a zero effective count, the carry is 0. The result is then the sign-extended low word (word form) or `src_i` unchanged (doubleword form).
- R7: `ca32_o` equals `ca_o` after every operation, in both forms.
- R8: Outputs update on the clock edge that samples `valid_i`=1. `valid_o` is 1 for exactly the cycles after such edges. Outputs hold their values while `valid_i` is 0.
- R9: While `rst` is high, and after it is released with no operation yet, the result, both flags and `valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 1 | 0 = word form, 1 = doubleword form |
| cnt_i | input | 7 | Shift count (register or immediate) |
| src_i | input | 64 | Source operand |
| res_o | output | 64 | Shifted result |
| ca_o | output | 1 | Carry flag |
| ca32_o | output | 1 | 32-bit carry flag |
| valid_o | output | 1 | Result valid, one-cycle pulse |

## Verification
The hardest case to reach is a negative operand that loses only zero bits, which must leave the carry clear. Random operands almost never produce it. The other hard case is a negative operand whose single lost 1 sits at the very bottom. Directed corner operands reach both cases at every count from 0 to 127: the minimum negative value, the minimum negative value plus one, a value with only the lowest bit set, all ones, and zero. Word-form counts with bit 6 set and bit 5 clear are also swept. This shows that only bit 5 triggers the word fill.

// File: rtl/sra_pkg.sv
package sra_pkg;
  typedef enum logic {
    OP_WORD  = 1'b0,
    OP_DWORD = 1'b1
  } sra_op_e;
endpackage

// File: rtl/sra_count_decode.sv
module sra_count_decode #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int WSH_W = $clog2(WORD_W),
  localparam int CNT_W = SH_W + 1
) (
  input  sra_pkg::sra_op_e op,
  input  logic [CNT_W-1:0] cnt,
  output logic [SH_W-1:0]  amt,
  output logic             ovf
);
  // Range bit sits just above the modulo field of each form.
  always_comb begin
    if (op == sra_pkg::OP_WORD) begin
      amt = {{(SH_W-WSH_W){1'b0}}, cnt[WSH_W-1:0]};
      ovf = cnt[WSH_W];
    end else begin
      amt = cnt[SH_W-1:0];
      ovf = cnt[SH_W];
    end
  end
endmodule

// File: rtl/sra_barrel.sv
module sra_barrel #(
  parameter int DATA_W = 64,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] shifted,
  output logic              lost_one
);
  // Logarithmic stages; each stage ORs the bits it drops into a sticky bit.
  always_comb begin
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] low_mask;
    logic              stk;
    cur = val;
    stk = 1'b0;
    for (int k = 0; k < SH_W; k++) begin
      low_mask = ~({DATA_W{1'b1}} << (1 << k));
      if (amt[k]) begin
        stk = stk | (|(cur & low_mask));
        cur = DATA_W'($signed(cur) >>> (1 << k));
      end
    end
    shifted  = cur;
    lost_one = stk;
  end
endmodule

// File: rtl/sra_carry_unit.sv
module sra_carry_unit #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ca_o,
  output logic              ca32_o,
  output logic              valid_o
);
  localparam int SH_W = $clog2(DATA_W);

  sra_pkg::sra_op_e  op;
  logic [SH_W-1:0]   amt;
  logic              ovf;
  logic              sign;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] shifted;
  logic              lost_one;
  logic [DATA_W-1:0] res_d;
  logic              ca_d;

  assign op = sra_pkg::sra_op_e'(op_i);

  sra_count_decode #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_dec (
    .op (op),
    .cnt(cnt_i),
    .amt(amt),
    .ovf(ovf)
  );

  // Word form is pre-extended so one 64-bit shifter serves both widths.
  always_comb begin
    if (op == sra_pkg::OP_WORD) begin
      sign    = src_i[WORD_W-1];
      operand = {{(DATA_W-WORD_W){src_i[WORD_W-1]}}, src_i[WORD_W-1:0]};
    end else begin
      sign    = src_i[DATA_W-1];
      operand = src_i;
    end
  end

  sra_barrel #(.DATA_W(DATA_W)) u_sh (
    .val     (operand),
    .amt     (amt),
    .shifted (shifted),
    .lost_one(lost_one)
  );

  always_comb begin
    if (ovf) begin
      res_d = {DATA_W{sign}};
      ca_d  = sign;
    end else begin
      res_d = shifted;
      ca_d  = sign & lost_one;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      ca_o    <= 1'b0;
      ca32_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o  <= res_d;
        ca_o   <= ca_d;
        ca32_o <= ca_d;
      end
    end
  end
endmodule

// File: rtl/sra_carry_unit_chk.sv
module sra_carry_unit_chk #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic              op_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] res_o,
  input logic              ca_o,
  input logic              ca32_o,
  input logic              valid_o
);
  localparam int WSH_W = $clog2(WORD_W);
  localparam int SH_W  = $clog2(DATA_W);

  assert_word_sext_R1: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !op_i) |=> (res_o[DATA_W-1:WORD_W-1] == {(DATA_W-WORD_W+1){res_o[WORD_W-1]}}));

  assert_word_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !op_i && cnt_i[WSH_W]) |=>
      (res_o == {DATA_W{$past(src_i[WORD_W-1])}}) && (ca_o == $past(src_i[WORD_W-1])));

  assert_dword_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i && cnt_i[SH_W]) |=>
      (res_o == {DATA_W{$past(src_i[DATA_W-1])}}) && (ca_o == $past(src_i[DATA_W-1])));

  assert_carry_needs_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ca_o) |-> res_o[DATA_W-1]);

  assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cnt_i == '0) |=> !ca_o);

  assert_ca32_mirror_R7: assert property (@(posedge clk) disable iff (rst)
    ca32_o == ca_o);

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(res_o) && $stable(ca_o)));
endmodule

bind sra_carry_unit sra_carry_unit_chk #(
  .DATA_W(DATA_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sra_carry_unit_test.sv
module sra_carry_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic        op_i;
  logic [6:0]  cnt_i;
  logic [63:0] src_i;
  logic [63:0] res_o;
  logic        ca_o, ca32_o, valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  sra_carry_unit uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .cnt_i(cnt_i),
    .src_i(src_i), .res_o(res_o), .ca_o(ca_o), .ca32_o(ca32_o), .valid_o(valid_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic op, input logic [6:0] cnt, input logic [63:0] src,
                                output logic [63:0] res, output logic ca, output string tag);
    logic signed [63:0] v;
    logic [63:0] lost;
    int s;
    if (!op) begin
      v = {{32{src[31]}}, src[31:0]};
      if (cnt[5]) begin
        res = {64{src[31]}}; ca = src[31]; tag = "R2";
        return;
      end
      s = int'(cnt[4:0]);
    end else begin
      v = src;
      if (cnt[6]) begin
        res = {64{src[63]}}; ca = src[63]; tag = "R4";
        return;
      end
      s = int'(cnt[5:0]);
    end
    res  = 64'(v >>> s);
    lost = (s == 0) ? 64'd0 : (64'(v) & ((64'd1 << s) - 64'd1));
    ca   = v[63] && (lost != 64'd0);
    tag  = (s == 0) ? "R6" : (op ? "R3" : "R1");
  endfunction

  task automatic run_op(input logic op, input logic [6:0] cnt, input logic [63:0] src);
    logic [63:0] er;
    logic ec;
    string tag;
    model(op, cnt, src, er, ec, tag);
    valid_i = 1'b1; op_i = op; cnt_i = cnt; src_i = src;
    @(negedge clk);
    valid_i = 1'b0;
    check(tag, res_o, er);
    check((tag == "R2" || tag == "R4" || tag == "R6") ? tag : "R5", 64'(ca_o), 64'(ec));
    check("R7", 64'(ca32_o), 64'(ca_o));
    check("R8", 64'(valid_o), 64'd1);
  endtask

  task automatic test_reset();
    rst = 1'b1; valid_i = 1'b1; op_i = 1'b1; cnt_i = 7'd3; src_i = '1;
    repeat (3) @(negedge clk);
    check("R9", res_o, 64'd0);
    check("R9", {62'd0, ca_o, ca32_o}, 64'd0);
    check("R9", 64'(valid_o), 64'd0);
    rst = 1'b0; valid_i = 1'b0;
    @(negedge clk);
    check("R9", res_o, 64'd0);
    check("R9", 64'(valid_o), 64'd0);
  endtask

  task automatic test_sweep_random(input logic op);
    for (int c = 0; c < 128; c++) begin
      run_op(op, 7'(c), {$urandom, $urandom});
      run_op(op, 7'(c), {$urandom, 1'b1, 31'($urandom)} | 64'h8000_0000_0000_0000);
    end
  endtask

  task automatic test_corners();
    logic [63:0] corners [6] = '{64'd0, '1, 64'h8000_0000_0000_0000,
                                 64'h8000_0000_0000_0001, 64'd1, 64'h0000_0000_8000_0001};
    for (int i = 0; i < 6; i++)
      for (int c = 0; c < 128; c++) begin
        run_op(1'b0, 7'(c), corners[i]);
        run_op(1'b1, 7'(c), corners[i]);
      end
    run_op(1'b0, 7'd1, 64'h0000_0000_8000_0000);
    check("R5", 64'(ca_o), 64'd0);
    run_op(1'b0, 7'd1, 64'h0000_0000_8000_0001);
    check("R5", 64'(ca_o), 64'd1);
    run_op(1'b0, 7'b100_0001, 64'h0000_0000_8000_0001);
    check("R1", res_o, 64'hFFFF_FFFF_C000_0000);
  endtask

  task automatic test_hold();
    logic [63:0] held;
    run_op(1'b1, 7'd4, 64'hF000_0000_0000_0013);
    held = res_o;
    op_i = 1'b0; cnt_i = 7'd0; src_i = 64'h1234;
    @(negedge clk);
    check("R8", 64'(valid_o), 64'd0);
    repeat (3) @(negedge clk);
    check("R8", res_o, held);
    check("R8", 64'(ca_o), 64'd1);
  endtask

  task automatic test_back_to_back();
    logic [63:0] e1, e2;
    logic c1, c2;
    string t;
    model(1'b0, 7'd8, 64'h0000_0000_F000_00FF, e1, c1, t);
    model(1'b1, 7'd65, 64'h8000_0000_0000_0000, e2, c2, t);
    valid_i = 1'b1; op_i = 1'b0; cnt_i = 7'd8; src_i = 64'h0000_0000_F000_00FF;
    @(negedge clk);
    check("R8", res_o, e1);
    check("R8", 64'(valid_o), 64'd1);
    op_i = 1'b1; cnt_i = 7'd65; src_i = 64'h8000_0000_0000_0000;
    @(negedge clk);
    valid_i = 1'b0;
    check("R8", res_o, e2);
    check("R4", 64'(ca_o), 64'(c2));
    check("R8", 64'(valid_o), 64'd1);
    @(negedge clk);
    check("R8", 64'(valid_o), 64'd0);
    check("R5", 64'(c1), 64'd1);
  endtask

  initial begin
    valid_i = 1'b0; op_i = 1'b0; cnt_i = '0; src_i = '0; rst = 1'b1;
    @(negedge clk);
    test_reset();
    test_sweep_random(1'b0);
    test_sweep_random(1'b1);
    test_corners();
    test_hold();
    test_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule